// File: doc/BRIEF.md
# Vector Branch-to-Link Sequencer

This unit runs a branch-to-link-register instruction across a vector of elements. A one-cycle start pulse captures the following: the element count, the five-bit branch options field, one condition bit per element, the count, link and current-address registers, the link and link-inversion flags, and the address-width mode. The unit then evaluates one element on each clock cycle.

For each element it can decrement the count, and it tests the count and the condition. It then decides whether to branch and whether to rewrite the link register. The loop ends at the first element that branches, or after the last element.

When the loop ends, the unit holds these results until the next accepted start:
- the next instruction address
- the final count and link values
- a taken flag
- a done flag

Surrounding fetch and register-file logic copies these results back. The link-inversion mode makes a vector branch-and-link useful. With link enable clear, the link register is rewritten only by the element that takes the branch. Earlier elements therefore all target the link value captured at the start.

Top module: `vbranch_link_unit`

## Requirements
- R1: After reset `busy_o`, `done_o` and `taken_o` are 0, and `nia_o`, `ctr_o` and `lr_o` are all zero.
- R2: The options field `bo_i` holds BO[k] in bit `4-k`. When BO[2] is 0, the count is decremented by one for every element evaluated. When BO[2] is 1, the count is unchanged.
- R3: The count check passes when BO[2] is 1, or when (the tested count is nonzero) XOR BO[3] is 1. The tested count is the value after that element's decrement. It covers all 64 bits when `mode64_i` is 1, and only bits 31:0 when `mode64_i` is 0.
- R4: The condition check passes when BO[0] is 1, or when `cr_i[i]` equals BO[1]. Here `i` is the element index, counted from 0 upward.
- R5: An element branches when both checks pass. The next address then becomes the link value held before that element, with bits 1:0 cleared. `taken_o` is set, and no further element is evaluated.
- R6: Each element's link write enable starts equal to `lk_i`. It is inverted when that element branches and `lru_i` is 1. When the enable is set, the link value becomes the current address plus 4. A later element's branch target uses the updated link value.
- R7: When no element branches, `nia_o` is the current address plus 4 and `taken_o` is 0.
- R8: With an element count of 0, `done_o` rises after the accepting edge. `ctr_o` and `lr_o` equal their captured inputs, and `nia_o` is the current address plus 4.
- R9: A start pulse while `busy_o` is 1 is ignored. After done, every output holds its value until the next accepted start.
- R10: Take the accepting edge as edge 0. `done_o` rises after edge N, where N is the number of elements evaluated. N is the element count, or k+1 when element k branches. `busy_o` and `done_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only when not busy |
| vl_i | input | $clog2(MAX_VL+1) | Element count; values above MAX_VL are clamped |
| bo_i | input | 5 | Branch options; BO[k] is in bit 4-k |
| cr_i | input | MAX_VL | Condition bit for each element; bit i belongs to element i |
| ctr_i | input | XLEN | Initial count register |
| lr_i | input | XLEN | Initial link register |
| cia_i | input | XLEN | Address of the current instruction |
| lk_i | input | 1 | Link write enable |
| lru_i | input | 1 | Link-inversion mode |
| mode64_i | input | 1 | 1 selects a full-width count test; 0 tests the low 32 bits |
| busy_o | output | 1 | Elements are being evaluated |
| done_o | output | 1 | Results valid; held until the next accepted start |
| taken_o | output | 1 | An element branched |
| nia_o | output | XLEN | Next instruction address |
| ctr_o | output | XLEN | Final count register |
| lr_o | output | XLEN | Final link register |

## Verification
The hardest situation to reach from the ports is an element whose branch target depends on a link value that an earlier element of the same run has just rewritten. This needs link enable set, no inversion, and condition bits that stay false for the first few elements. The stimulus sets only a later bit of `cr_i`, so the expected address must come from the current address rather than from the link input. A second awkward case is a start pulse that arrives mid-run. The driver pulses start with different operands a few cycles after the first start. The scoreboard then expects the first run's results at the first run's completion cycle. Count cases that differ between 32-bit and full-width testing use a count whose upper half is nonzero.

// File: rtl/bcl_pkg.sv
package bcl_pkg;
  localparam int BO_W = 5;
  typedef logic [BO_W-1:0] bo_t;

  // Branch option bit k is stored MSB-first: BO[k] lives in bit (4-k).
  function automatic logic bo_at(bo_t b, int k);
    return b[BO_W-1-k];
  endfunction
endpackage

// File: rtl/bcl_cond_eval.sv
module bcl_cond_eval
  import bcl_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] ctr_cur,
  input  bo_t             bo,
  input  logic            cr_bit,
  input  logic            mode64,
  output logic [XLEN-1:0] ctr_next,
  output logic            ctr_ok,
  output logic            cond_ok
);
  localparam int HALF = (XLEN > 32) ? 32 : XLEN;

  logic nz;

  always_comb begin
    ctr_next = bo_at(bo, 2) ? ctr_cur : (ctr_cur - XLEN'(1));
  end

  generate
    if (XLEN > 32) begin : g_wide
      always_comb begin
        if (mode64) nz = |ctr_next;
        else        nz = |ctr_next[HALF-1:0];
      end
    end else begin : g_narrow
      always_comb nz = |ctr_next;
    end
  endgenerate

  always_comb begin
    ctr_ok  = bo_at(bo, 2) | (nz ^ bo_at(bo, 3));
    cond_ok = bo_at(bo, 0) | (cr_bit == bo_at(bo, 1));
  end
endmodule

// File: rtl/bcl_link_ctl.sv
module bcl_link_ctl #(
  parameter int XLEN = 64
) (
  input  logic            ctr_ok,
  input  logic            cond_ok,
  input  logic            lk,
  input  logic            lru,
  input  logic [XLEN-1:0] lr_cur,
  input  logic [XLEN-1:0] cia,
  output logic            take,
  output logic            lr_we,
  output logic [XLEN-1:0] lr_wdata,
  output logic [XLEN-1:0] nia_tgt
);
  always_comb begin
    take     = ctr_ok & cond_ok;
    lr_we    = lk ^ (take & lru);
    lr_wdata = cia + XLEN'(4);
    nia_tgt  = {lr_cur[XLEN-1:2], 2'b00};
  end
endmodule

// File: rtl/bcl_seq.sv
module bcl_seq #(
  parameter int MAX_VL = 16,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int IDXW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [VLW-1:0]  vl,
  input  logic            stop,
  output logic            busy,
  output logic            done,
  output logic            step,
  output logic [IDXW-1:0] idx
);
  logic [VLW-1:0] vl_q;
  logic           last;

  always_comb begin
    last = (VLW'(idx) + VLW'(1)) == vl_q;
    step = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      vl_q <= '0;
    end else if (accept) begin
      vl_q <= vl;
      idx  <= '0;
      busy <= (vl != '0);
      done <= (vl == '0);
    end else if (busy) begin
      idx <= idx + IDXW'(1);
      if (stop || last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vbranch_link_unit.sv
module vbranch_link_unit
  import bcl_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int XLEN   = 64,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int IDXW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic [4:0]        bo_i,
  input  logic [MAX_VL-1:0] cr_i,
  input  logic [XLEN-1:0]   ctr_i,
  input  logic [XLEN-1:0]   lr_i,
  input  logic [XLEN-1:0]   cia_i,
  input  logic              lk_i,
  input  logic              lru_i,
  input  logic              mode64_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   nia_o,
  output logic [XLEN-1:0]   ctr_o,
  output logic [XLEN-1:0]   lr_o
);
  // Captured operands
  bo_t               bo_q;
  logic [MAX_VL-1:0] cr_q;
  logic [XLEN-1:0]   ctr_q, lr_q, cia_q, nia_q;
  logic              lk_q, lru_q, m64_q, taken_q;

  logic              accept, step;
  logic [IDXW-1:0]   idx;
  logic [VLW-1:0]    vl_c;

  // Per-element results
  logic [XLEN-1:0]   ctr_nx, lr_wdata, nia_tgt;
  logic              ctr_ok, cond_ok, take, lr_we;

  always_comb begin
    accept = start_i & ~busy_o;
    vl_c   = (vl_i > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl_i;
  end

  bcl_seq #(.MAX_VL(MAX_VL)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .vl     (vl_c),
    .stop   (take),
    .busy   (busy_o),
    .done   (done_o),
    .step   (step),
    .idx    (idx)
  );

  bcl_cond_eval #(.XLEN(XLEN)) u_eval (
    .ctr_cur  (ctr_q),
    .bo       (bo_q),
    .cr_bit   (cr_q[idx]),
    .mode64   (m64_q),
    .ctr_next (ctr_nx),
    .ctr_ok   (ctr_ok),
    .cond_ok  (cond_ok)
  );

  bcl_link_ctl #(.XLEN(XLEN)) u_link (
    .ctr_ok   (ctr_ok),
    .cond_ok  (cond_ok),
    .lk       (lk_q),
    .lru      (lru_q),
    .lr_cur   (lr_q),
    .cia      (cia_q),
    .take     (take),
    .lr_we    (lr_we),
    .lr_wdata (lr_wdata),
    .nia_tgt  (nia_tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bo_q    <= '0;
      cr_q    <= '0;
      ctr_q   <= '0;
      lr_q    <= '0;
      cia_q   <= '0;
      nia_q   <= '0;
      lk_q    <= 1'b0;
      lru_q   <= 1'b0;
      m64_q   <= 1'b0;
      taken_q <= 1'b0;
    end else if (accept) begin
      bo_q    <= bo_i;
      cr_q    <= cr_i;
      ctr_q   <= ctr_i;
      lr_q    <= lr_i;
      cia_q   <= cia_i;
      nia_q   <= cia_i + XLEN'(4);
      lk_q    <= lk_i;
      lru_q   <= lru_i;
      m64_q   <= mode64_i;
      taken_q <= 1'b0;
    end else if (step) begin
      ctr_q <= ctr_nx;
      if (lr_we) lr_q <= lr_wdata;
      if (take) begin
        nia_q   <= nia_tgt;
        taken_q <= 1'b1;
      end
    end
  end

  always_comb begin
    taken_o = taken_q;
    nia_o   = nia_q;
    ctr_o   = ctr_q;
    lr_o    = lr_q;
  end
endmodule

// File: rtl/bcl_chk.sv
module bcl_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            taken_o,
  input logic [XLEN-1:0] nia_o,
  input logic [XLEN-1:0] ctr_o,
  input logic [XLEN-1:0] lr_o,
  input logic [4:0]      bo_q,
  input logic [XLEN-1:0] cia_q
);
  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R5
  taken_done_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> done_o);

  // R5
  nia_align_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (nia_o[1:0] == 2'b00));

  // R2
  ctr_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !bo_q[2]) |=> (ctr_o == $past(ctr_o) - XLEN'(1)));

  // R2
  ctr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && bo_q[2]) |=> $stable(ctr_o));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(nia_o) && $stable(ctr_o)
                               && $stable(lr_o) && $stable(taken_o)));

  // R9
  busy_latch_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(cia_q));
endmodule

bind vbranch_link_unit bcl_chk #(.XLEN(XLEN)) i_bcl_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .taken_o (taken_o),
  .nia_o   (nia_o),
  .ctr_o   (ctr_o),
  .lr_o    (lr_o),
  .bo_q    (bo_q),
  .cia_q   (cia_q)
);

// File: tb/test_vbranch_link_unit.sv
module test_vbranch_link_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_VL = 16;
  localparam int XLEN   = 64;
  localparam int VLW    = $clog2(MAX_VL + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [VLW-1:0]    vl_i = '0;
  logic [4:0]        bo_i = '0;
  logic [MAX_VL-1:0] cr_i = '0;
  logic [XLEN-1:0]   ctr_i = '0, lr_i = '0, cia_i = '0;
  logic              lk_i = 1'b0, lru_i = 1'b0, mode64_i = 1'b0;
  logic              busy_o, done_o, taken_o;
  logic [XLEN-1:0]   nia_o, ctr_o, lr_o;

  vbranch_link_unit #(.MAX_VL(MAX_VL), .XLEN(XLEN)) i_vbranch_link_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .vl_i(vl_i), .bo_i(bo_i),
    .cr_i(cr_i), .ctr_i(ctr_i), .lr_i(lr_i), .cia_i(cia_i), .lk_i(lk_i),
    .lru_i(lru_i), .mode64_i(mode64_i), .busy_o(busy_o), .done_o(done_o),
    .taken_o(taken_o), .nia_o(nia_o), .ctr_o(ctr_o), .lr_o(lr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [XLEN-1:0] nia, ctr, lr;
    logic            taken;
    int              nel;
    int              due;
    string           name;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input string req, input string what, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic exp_t model(input int vl, input logic [4:0] bo, input logic [MAX_VL-1:0] cr,
                                 input logic [XLEN-1:0] ctr, input logic [XLEN-1:0] lr,
                                 input logic [XLEN-1:0] cia, input logic lk, input logic lru,
                                 input logic m64);
    exp_t e;
    logic b0, b1, b2, b3;
    b0 = bo[4]; b1 = bo[3]; b2 = bo[2]; b3 = bo[1];
    if (vl > MAX_VL) vl = MAX_VL;
    e.nia = cia + 4; e.taken = 1'b0; e.nel = 0;
    for (int i = 0; i < vl; i++) begin
      logic nz, cok, dok, tk, we;
      if (!b2) ctr = ctr - 1;
      nz  = m64 ? (ctr != 0) : (ctr[31:0] != 0);
      cok = b2 | (nz ^ b3);
      dok = b0 | (cr[i] == b1);
      tk  = cok & dok;
      we  = lk;
      e.nel = i + 1;
      if (tk) begin
        e.nia = {lr[XLEN-1:2], 2'b00};
        e.taken = 1'b1;
        if (lru) we = ~we;
      end
      if (we) lr = cia + 4;
      if (tk) break;
    end
    e.ctr = ctr; e.lr = lr;
    return e;
  endfunction

  // Driver: push expectation, pulse start, optionally inject a start while busy
  task automatic run_case(input string name, input int vl, input logic [4:0] bo,
                          input logic [MAX_VL-1:0] cr, input logic [XLEN-1:0] ctr,
                          input logic [XLEN-1:0] lr, input logic [XLEN-1:0] cia,
                          input logic lk, input logic lru, input logic m64,
                          input bit poke_busy);
    exp_t e;
    e = model(vl, bo, cr, ctr, lr, cia, lk, lru, m64);
    e.name = name;
    @(negedge clk);
    e.due = cyc + 1 + e.nel;
    sb.push_back(e);
    start_i = 1'b1; vl_i = VLW'(vl); bo_i = bo; cr_i = cr; ctr_i = ctr;
    lr_i = lr; cia_i = cia; lk_i = lk; lru_i = lru; mode64_i = m64;
    @(negedge clk);
    start_i = 1'b0;
    if (poke_busy) begin
      @(negedge clk);
      // R9: second start while busy must be ignored
      start_i = 1'b1; vl_i = VLW'(1); bo_i = 5'b10100; ctr_i = '1; lr_i = '1;
      cia_i = 64'hDEAD_0000; lk_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    do @(posedge clk); while (sb.size() != 0);
  endtask

  // Monitor: compare at the predicted completion cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        if (sb[0].nel > 0 && cyc == sb[0].due - 1)
          chk("R10", {sb[0].name, " done early"}, XLEN'(done_o), XLEN'(0));
        if (cyc == sb[0].due) begin
          exp_t e;
          e = sb.pop_front();
          chk("R10", {e.name, " done"}, XLEN'(done_o), XLEN'(1));
          chk("R5_R7", {e.name, " nia"}, nia_o, e.nia);
          chk("R2_R3", {e.name, " ctr"}, ctr_o, e.ctr);
          chk("R6", {e.name, " lr"}, lr_o, e.lr);
          chk("R4_R5", {e.name, " taken"}, XLEN'(taken_o), XLEN'(e.taken));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "busy", XLEN'(busy_o), '0);
    chk("R1", "done", XLEN'(done_o), '0);
    chk("R1", "taken", XLEN'(taken_o), '0);
    chk("R1", "nia", nia_o, '0);
    chk("R1", "ctr", ctr_o, '0);
    chk("R1", "lr", lr_o, '0);

    // R8 zero-length vector
    run_case("R8 vl0", 0, 5'b10100, '1, 64'h55, 64'h1000, 64'h2000, 1'b1, 1'b0, 1'b1, 0);
    // R5 always-branch at element 0, link written
    run_case("R5 always", 4, 5'b10100, '0, 64'h7, 64'h3003, 64'h4000, 1'b1, 1'b0, 1'b1, 0);
    // R2 R3 count down to zero, branch on zero
    run_case("R3 zero", 8, 5'b10010, '0, 64'h3, 64'h5000, 64'h6000, 1'b0, 1'b0, 1'b1, 0);
    // R3 32-bit versus 64-bit count test
    run_case("R3 m32", 4, 5'b10010, '0, 64'h1_0000_0002, 64'h7000, 64'h8000, 1'b0, 1'b0, 1'b0, 0);
    run_case("R3 m64", 4, 5'b10010, '0, 64'h1_0000_0002, 64'h7000, 64'h8000, 1'b0, 1'b0, 1'b1, 0);
    // R4 condition bit at element 6
    run_case("R4 cr6", 8, 5'b01100, 16'h0040, 64'h9, 64'h9000, 64'hA000, 1'b0, 1'b0, 1'b1, 0);
    // R6 inversion with link clear: link written only by the taken element
    run_case("R6 lru0", 8, 5'b01100, 16'h0008, 64'h9, 64'hB000, 64'hC000, 1'b0, 1'b1, 1'b1, 0);
    // R6 inversion with link set, no branch: link written each element
    run_case("R6 lru1", 5, 5'b01100, 16'h0000, 64'h9, 64'hB004, 64'hC100, 1'b1, 1'b1, 1'b1, 0);
    // R6 link set without inversion: target uses rewritten link
    run_case("R6 clobber", 8, 5'b01100, 16'h0004, 64'h9, 64'hD000, 64'hE000, 1'b1, 1'b0, 1'b1, 0);
    // R7 full-length vector with no branch
    run_case("R7 full", MAX_VL, 5'b00100, '1, 64'h9, 64'hF000, 64'hF100, 1'b0, 1'b0, 1'b1, 0);
    // R9 start pulse while busy
    run_case("R9 poke", 8, 5'b00100, '1, 64'h21, 64'h1234, 64'h5678, 1'b0, 1'b0, 1'b1, 1);

    // R9 outputs hold after done
    begin
      logic [XLEN-1:0] n0, c0, l0;
      @(negedge clk);
      n0 = nia_o; c0 = ctr_o; l0 = lr_o;
      repeat (6) @(negedge clk);
      chk("R9", "hold nia", nia_o, n0);
      chk("R9", "hold ctr", ctr_o, c0);
      chk("R9", "hold lr", lr_o, l0);
      chk("R9", "hold done", XLEN'(done_o), XLEN'(1));
    end

    // Mixed patterns
    for (int k = 0; k < 30; k++) begin
      logic [XLEN-1:0] c;
      c = {$urandom_range(1,0) ? 32'h0 : 32'h1, 32'($urandom_range(5,0))};
      run_case("mix", $urandom_range(MAX_VL, 0), 5'($urandom), MAX_VL'($urandom),
               c, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom),
               1'($urandom), 1'($urandom), 0);
    end

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule